// File: doc/BRIEF.md
# SPI Register Access Front-End

This block is the slave side of a serial register port. A host controller drives a serial clock, an active-low select, and a data-in line. It opens every burst with a command byte that names one of 32 register numbers and a direction. The bytes that follow all move in that direction until select is released. The block turns each completed byte into a one-cycle strobe toward a register file. Three register numbers are FIFO ports and get push or pop strobes. All other numbers get register write or read strobes. Write data and the current register number are presented with each strobe.

The current register number changes during a burst according to where the burst started. A FIFO port never moves. A burst that starts inside the low control window (13 to 20) or the high control window (21 to 31) steps up by one after every byte and then parks on the last register of its window. Any other number stays fixed for the whole burst.

When duplex operation is enabled, the block shifts an 8-bit interrupt-status snapshot out on the data-out line while the command byte comes in. The serial clock is sampled by the faster system clock through a synchronizer, so the serial clock must be slow relative to the system clock.

Top module: `spi_reg_frontend`

## Requirements
- R1: The command byte arrives MSB first. Bits 7..3 give the register number, bit 1 selects write (1) or read (0), and bits 2 and 0 have no effect on addressing or direction.
- R2: Each complete data byte of a write burst produces exactly one single-cycle strobe. The strobe is `fifo_push` when the register number is 1, 2 or 4, and `reg_wr` otherwise. `wr_data` carries the byte, received MSB first, and `reg_addr` holds that byte's register number.
- R3: Each complete data byte of a read burst produces exactly one single-cycle strobe: `fifo_pop` for register 1, 2 or 4, `reg_rd` otherwise. The byte shifted out MSB first is the value of `rd_data` for that register, taken before the byte's first clock edge.
- R4: In a burst addressed to register 1, 2 or 4, every byte targets the same register number.
- R5: A burst starting at register 13..20 advances one register per byte until 20 and stays at 20 afterwards.
- R6: A burst starting at register 21..31 advances one register per byte until 31 and stays at 31 afterwards.
- R7: A burst starting at register 0, 3 or 5..12 keeps its register number for every byte.
- R8: With `duplex_en` high, the bits shifted out during the command byte are `irq_status`, bit 7 first. With `duplex_en` low, those bits are all zero.
- R9: Releasing select part-way through a byte discards that byte with no strobe. The next burst begins again with a command byte.
- R10: After reset, no strobe is active, `spi_miso` is low and `reg_addr` is 0.
- R11: At most one of the four strobes is high in any cycle, and no strobe lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idle low, data sampled on the rising edge |
| spi_cs_n | input | 1 | Active-low select; a low period is one burst |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, changes after falling edges |
| duplex_en | input | 1 | Return the status snapshot during the command byte |
| irq_status | input | 8 | Interrupt-request snapshot returned in duplex mode |
| reg_addr | output | 5 | Register number of the current byte |
| rd_data | input | 8 | Read value of the register at `reg_addr` (FIFO head for ports) |
| wr_data | output | 8 | Last received data byte, valid with a write strobe |
| reg_wr | output | 1 | Control-register write strobe |
| reg_rd | output | 1 | Control-register read strobe |
| fifo_push | output | 1 | FIFO port write strobe |
| fifo_pop | output | 1 | FIFO port read strobe |

## Verification
The bench uses the default two-stage synchronizer and a serial clock half-period of eight system clocks. This leaves several cycles between each byte boundary and the next falling edge. That spacing puts the strobe, the address step and the next read-value fetch all inside the window the design relies on. The transfers that reach this window cover both sticky window ends, a FIFO port read whose head value changes with each pop, and an abort in mid-byte. Status return is exercised with duplex mode both on and off.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int ADDR_W   = 5;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // register numbers that are FIFO ports: 1, 2, 4
    localparam logic [NUM_REGS-1:0] FIFO_PORT_MASK = NUM_REGS'(32'h0000_0016);

    localparam addr_t LOW_FIRST  = addr_t'(13);
    localparam addr_t LOW_LAST   = addr_t'(20);
    localparam addr_t HIGH_FIRST = addr_t'(21);
    localparam addr_t HIGH_LAST  = addr_t'(31);

    localparam int CMD_DIR_BIT = 1;

    typedef enum logic [1:0] {WIN_HOLD, WIN_LOW, WIN_HIGH} win_e;
    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        addr_t num;
        logic  wr;
    } cmd_t;

    function automatic logic is_fifo_port(addr_t a);
        return FIFO_PORT_MASK[a];
    endfunction

    function automatic win_e window_of(addr_t a);
        if (is_fifo_port(a))                  return WIN_HOLD;
        if (a >= LOW_FIRST && a <= LOW_LAST)  return WIN_LOW;
        if (a >= HIGH_FIRST && a <= HIGH_LAST) return WIN_HIGH;
        return WIN_HOLD;
    endfunction

    function automatic addr_t next_addr(addr_t a, win_e w);
        case (w)
            WIN_LOW:  return (a < LOW_LAST)  ? a + 1'b1 : a;
            WIN_HIGH: return (a < HIGH_LAST) ? a + 1'b1 : a;
            default:  return a;
        endcase
    endfunction

    function automatic cmd_t decode_cmd(byte_t b);
        cmd_t c;
        c.num = b[BYTE_W-1 -: ADDR_W];
        c.wr  = b[CMD_DIR_BIT];
        return c;
    endfunction

endpackage

// File: rtl/spi_fe_sampler.sv
module spi_fe_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic sel_start,
    output logic mosi_s
);
    // bundle order: {sck, cs_n, mosi}
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] cur;
    logic [2:0] synced;
    logic       sck_prev;
    logic       sel_prev;

    assign cur = {sck, cs_n, mosi};

    generate
        if (STAGES <= 1) begin : g_single
            logic [2:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= IDLE;
                else     q <= cur;
            end
            assign synced = q;
        end else begin : g_chain
            logic [STAGES-1:0][2:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= {STAGES{IDLE}};
                else     q <= {q[STAGES-2:0], cur};
            end
            assign synced = q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            sel_prev <= 1'b0;
        end else begin
            sck_prev <= synced[2];
            sel_prev <= ~synced[1];
        end
    end

    assign sel       = ~synced[1];
    assign sel_start = sel & ~sel_prev;
    assign sck_rise  = sel & synced[2] & ~sck_prev;
    assign sck_fall  = sel & ~synced[2] & sck_prev;
    assign mosi_s    = synced[0];

endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter
    import spi_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  sel_start,
    input  logic  sck_rise,
    input  logic  sck_fall,
    input  logic  mosi_s,
    input  byte_t start_val,
    input  logic  load_req,
    input  byte_t load_val,
    output logic  byte_done,
    output byte_t rx_byte,
    output logic  miso
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    byte_t             tx_sh;
    logic              load_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!sel) begin
                bit_cnt   <= '0;
                load_pend <= 1'b0;
                tx_sh     <= '0;
            end else begin
                if (sel_start) begin
                    tx_sh     <= start_val;
                    bit_cnt   <= '0;
                    load_pend <= 1'b0;
                end
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sh, mosi_s};
                    end
                end
                if (load_req) load_pend <= 1'b1;
                if (sck_fall) begin
                    if (load_pend) begin
                        tx_sh     <= load_val;
                        load_pend <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso = sel & tx_sh[BYTE_W-1];

    // R9: losing select clears the bit position and never completes a byte
    p_no_partial_r9: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (bit_cnt == '0 && !byte_done));

endmodule

// File: rtl/spi_fe_addr_track.sv
module spi_fe_addr_track
    import spi_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t start_addr,
    input  logic  adv,
    output addr_t addr
);
    win_e win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            win_q <= WIN_HOLD;
        end else if (start) begin
            addr  <= start_addr;
            win_q <= window_of(start_addr);
        end else if (adv) begin
            addr <= next_addr(addr, win_q);
        end
    end

    p_low_window_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !start && win_q == WIN_LOW) |=>
            (addr >= LOW_FIRST && addr <= LOW_LAST && addr >= $past(addr)));

    p_high_window_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !start && win_q == WIN_HIGH) |=>
            (addr >= HIGH_FIRST && addr >= $past(addr)));

    // R7, and R4 for the FIFO ports, which always fall in the hold class
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && !start && win_q == WIN_HOLD) |=> $stable(addr));

endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       duplex_en,
    input  logic [7:0] irq_status,
    output logic [4:0] reg_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] wr_data,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic       fifo_push,
    output logic       fifo_pop
);
    logic   sck_rise, sck_fall, sel, sel_start, mosi_s;
    logic   byte_done;
    byte_t  rx_byte;
    byte_t  start_val, load_val;
    logic   load_req_q, adv_pend_q, dir_wr_q;
    phase_e phase_q;
    cmd_t   cmd;
    logic   trk_start;
    addr_t  cur_addr;

    spi_fe_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sel       (sel),
        .sel_start (sel_start),
        .mosi_s    (mosi_s)
    );

    assign start_val = duplex_en ? irq_status : '0;
    assign load_val  = dir_wr_q ? '0 : rd_data;

    spi_fe_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .sel_start (sel_start),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .start_val (start_val),
        .load_req  (load_req_q),
        .load_val  (load_val),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    assign cmd       = decode_cmd(rx_byte);
    assign trk_start = sel && byte_done && (phase_q == PH_CMD);

    spi_fe_addr_track u_track (
        .clk        (clk),
        .rst        (rst),
        .start      (trk_start),
        .start_addr (cmd.num),
        .adv        (adv_pend_q),
        .addr       (cur_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_CMD;
            dir_wr_q   <= 1'b0;
            adv_pend_q <= 1'b0;
            load_req_q <= 1'b0;
            reg_wr     <= 1'b0;
            reg_rd     <= 1'b0;
            fifo_push  <= 1'b0;
            fifo_pop   <= 1'b0;
        end else begin
            reg_wr     <= 1'b0;
            reg_rd     <= 1'b0;
            fifo_push  <= 1'b0;
            fifo_pop   <= 1'b0;
            adv_pend_q <= 1'b0;
            load_req_q <= adv_pend_q;
            if (!sel) begin
                phase_q <= PH_CMD;
            end else if (byte_done) begin
                if (phase_q == PH_CMD) begin
                    phase_q    <= PH_DATA;
                    dir_wr_q   <= cmd.wr;
                    load_req_q <= 1'b1;
                end else begin
                    if (dir_wr_q) begin
                        fifo_push <= is_fifo_port(cur_addr);
                        reg_wr    <= ~is_fifo_port(cur_addr);
                    end else begin
                        fifo_pop  <= is_fifo_port(cur_addr);
                        reg_rd    <= ~is_fifo_port(cur_addr);
                    end
                    adv_pend_q <= 1'b1;
                end
            end
        end
    end

    assign reg_addr = cur_addr;
    assign wr_data  = rx_byte;

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_wr, reg_rd, fifo_push, fifo_pop}));

    p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd || fifo_push || fifo_pop) |=>
            !(reg_wr || reg_rd || fifo_push || fifo_pop));

    p_fifo_kind_r2: assert property (@(posedge clk) disable iff (rst)
        (fifo_push || fifo_pop) |-> is_fifo_port(reg_addr));

    p_reg_kind_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |-> !is_fifo_port(reg_addr));

    p_cmd_addr_r1: assert property (@(posedge clk) disable iff (rst)
        trk_start |=> (reg_addr == $past(rx_byte[7:3])));

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !(reg_wr || reg_rd || fifo_push || fifo_pop || spi_miso));

endmodule

// File: tb/sim_spi_reg_frontend.sv
module sim_spi_reg_frontend;
    import spi_fe_pkg::*;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       duplex_en = 1'b0;
    logic [7:0] irq_status = 8'h00;
    logic [4:0] reg_addr;
    logic [7:0] rd_data;
    logic [7:0] wr_data;
    logic       reg_wr, reg_rd, fifo_push, fifo_pop;

    int checks = 0;
    int errors = 0;

    logic [7:0] regs [32];
    logic [7:0] pop_cnt = 8'h00;
    int         log_n = 0;
    int         log_kind [64];   // 0 write, 1 read, 2 push, 3 pop
    int         log_addr [64];
    int         log_data [64];
    logic [7:0] tx_buf [16];
    logic [7:0] rx_buf [16];
    logic [7:0] cmd_rx;

    always #2 clk = ~clk;

    spi_reg_frontend #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .duplex_en(duplex_en),
        .irq_status(irq_status), .reg_addr(reg_addr), .rd_data(rd_data),
        .wr_data(wr_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop)
    );

    function automatic logic fifo_num(input logic [4:0] a);
        return (a == 5'd1) || (a == 5'd2) || (a == 5'd4);
    endfunction

    always_comb rd_data = fifo_num(reg_addr) ? 8'hA0 + pop_cnt : regs[reg_addr];

    always @(posedge clk) begin
        if (!rst && (reg_wr || reg_rd || fifo_push || fifo_pop)) begin
            if (log_n < 64) begin
                log_kind[log_n] = reg_wr ? 0 : reg_rd ? 1 : fifo_push ? 2 : 3;
                log_addr[log_n] = int'(reg_addr);
                log_data[log_n] = int'(wr_data);
            end
            log_n = log_n + 1;
            if (reg_wr) regs[reg_addr] = wr_data;
            if (fifo_pop) pop_cnt = pop_cnt + 8'd1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int nbits, input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            @(negedge clk);
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic burst(input logic [7:0] cmd, input int n);
        log_n = 0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        xfer(8, cmd, cmd_rx);
        for (int k = 0; k < n; k++) xfer(8, tx_buf[k], rx_buf[k]);
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic write_seq(input string tag, input logic [7:0] cmd, input int n,
                             input int first, input int last, input int kind);
        int exp_a;
        for (int k = 0; k < n; k++) tx_buf[k] = 8'h30 + 8'(k * 7);
        burst(cmd, n);
        chk({tag, " count"}, log_n, n);
        exp_a = first;
        for (int k = 0; k < n; k++) begin
            chk({tag, " kind"}, log_kind[k], kind);
            chk({tag, " addr"}, log_addr[k], exp_a);
            chk({tag, " data"}, log_data[k], int'(tx_buf[k]));
            if (exp_a < last) exp_a++;
        end
    endtask

    task automatic t_reset;
        chk("R10 reg_addr", int'(reg_addr), 0);
        chk("R10 miso", int'(spi_miso), 0);
        chk("R10 strobes", log_n, 0);
    endtask

    task automatic t_fifo_write;   // R2 R4 R1: 0x12 writes port 2
        write_seq("R2 R4 fifo write", 8'h12, 3, 2, 2, 2);
    endtask

    task automatic t_low_window;   // R5
        write_seq("R5 start 20", 8'hA2, 3, 20, 20, 0);
        write_seq("R5 start 18", 8'h92, 4, 18, 20, 0);
    endtask

    task automatic t_high_window;  // R6
        write_seq("R6 start 29", 8'hEA, 4, 29, 31, 0);
        write_seq("R6 start 21", 8'hAA, 2, 21, 31, 0);
    endtask

    task automatic t_hold;         // R7
        write_seq("R7 start 9", 8'h4A, 3, 9, 9, 0);
    endtask

    task automatic t_reg_read;     // R3 R5
        regs[15] = 8'h5C; regs[16] = 8'h81; regs[17] = 8'h3E;
        burst(8'h78, 3);
        chk("R3 read count", log_n, 3);
        chk("R3 byte0", int'(rx_buf[0]), 'h5C);
        chk("R3 byte1", int'(rx_buf[1]), 'h81);
        chk("R3 byte2", int'(rx_buf[2]), 'h3E);
        for (int k = 0; k < 3; k++) begin
            chk("R3 kind", log_kind[k], 1);
            chk("R5 read addr", log_addr[k], 15 + k);
        end
    endtask

    task automatic t_fifo_read;    // R3 R4
        pop_cnt = 8'h00;
        burst(8'h08, 3);
        chk("R3 pop count", log_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R3 fifo byte", int'(rx_buf[k]), 'hA0 + k);
            chk("R4 pop kind", log_kind[k], 3);
            chk("R4 pop addr", log_addr[k], 1);
        end
    endtask

    task automatic t_duplex;       // R8
        regs[9] = 8'h6B;
        duplex_en = 1'b1;
        irq_status = 8'hC5;
        burst(8'h48, 1);
        chk("R8 status on", int'(cmd_rx), 'hC5);
        chk("R3 after status", int'(rx_buf[0]), 'h6B);
        duplex_en = 1'b0;
        burst(8'h48, 1);
        chk("R8 status off", int'(cmd_rx), 0);
    endtask

    task automatic t_cmd_bits;     // R1: bits 2 and 0 set
        write_seq("R1 stray bits write", 8'h67, 2, 12, 12, 0);
        regs[9] = 8'h2D;
        burst(8'h4D, 1);
        chk("R1 stray bits read kind", log_kind[0], 1);
        chk("R1 stray bits read addr", log_addr[0], 9);
        chk("R1 stray bits read data", int'(rx_buf[0]), 'h2D);
    endtask

    task automatic t_abort;        // R9
        logic [7:0] junk;
        log_n = 0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        xfer(8, 8'h52, junk);
        xfer(8, 8'h11, junk);
        xfer(4, 8'hFF, junk);
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 partial dropped", log_n, 1);
        chk("R9 full byte", log_data[0], 'h11);
        tx_buf[0] = 8'h33;
        burst(8'h52, 1);
        chk("R9 fresh command count", log_n, 1);
        chk("R9 fresh command addr", log_addr[0], 10);
        chk("R9 reg value", int'(regs[10]), 'h33);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset;
        t_fifo_write;
        t_low_window;
        t_high_window;
        t_hold;
        t_reg_read;
        t_fifo_read;
        t_duplex;
        t_cmd_bits;
        t_abort;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule